// File: doc/BRIEF.md
# Bus Chip-Select and Acknowledge Pacer

This block watches each processor bus cycle, works out which on-board device owns the address, and drives that device's active-low chip-select. It then paces the transfer-acknowledge line so that each beat of the transfer finishes after a wait count fixed per device. Four-beat bursts follow a per-device beat pattern. The supervisor CPU-space cycles, such as interrupt acknowledge and the base-address register access, are not memory cycles, so they select nothing.

A transfer starts when `xfer_start` is high at a rising clock edge while the block is idle. The address and cycle codes are sampled only at that edge. From then on the block runs on its own until the last acknowledge, or until the no-response timeout. A start seen while a transfer is in flight is dropped. Only address bits 27..0 are decoded, so the on-board space is 256 MB. A device smaller than its window answers at every alias inside the window.

Top module: `bus_select_pacer`

## Requirements
- R1: While reset is held and right after it, all of `cs_n` are high and `xfer_ack` and `xfer_err` are low.
- R2: A start sampled at edge E0 drives exactly one `cs_n` bit low, visible after E0. The bit depends on the window: bit0 flash 0x0000000–0x01FFFFF; bit1 fast SRAM bank A 0x03C0000–0x03CFFFF; bit2 fast SRAM bank B 0x03E0000–0x03EFFFF; bit3 DRAM from 0x0400000; bit4 companion internal memory 0x1210000–0x1211FFF; bit5 status register 0x1230000–0x1231FFF.
- R3: Address bits 31..28 do not affect selection. Every address inside a window selects its device, whatever the low offset.
- R4: The DRAM window ends just below 0x0400000 + (1 MB << `dram_size`). This gives upper limits of 0x04FFFFF, 0x05FFFFF, 0x07FFFFF and 0x0BFFFFF for codes 0..3.
- R5: A cycle with `xfer_mod` = 3'b111, or with `xfer_type` = 2'b11, selects no device.
- R6: Flash takes 4 clocks per beat. The acknowledge for beat n (n = 1..4) is high in the cycle 4n clocks after E0.
- R7: An SRAM burst is acknowledged 3,1,1,1 clocks apart, at cycles 3, 4, 5 and 6 after E0. A single SRAM transfer is acknowledged at cycle 3.
- R8: A DRAM burst is acknowledged 3,2,2,2 clocks apart, at cycles 3, 5, 7 and 9 after E0.
- R9: Internal-memory and status-register accesses are acknowledged once, at cycle 2 after E0, even when `xfer_burst` is high.
- R10: When no device decodes, no chip-select falls and `xfer_ack` stays low. `xfer_err` is then high for exactly one cycle, 16 clocks after E0.
- R11: `xfer_ack` is high for one cycle per beat and only while a chip-select is low. The chip-select rises in the cycle after the last acknowledge.
- R12: A start sampled while a transfer or timeout is in flight changes neither the chip-selects nor the acknowledge timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Cycle address, sampled with the start |
| xfer_mod | input | 3 | Transfer-modifier code |
| xfer_type | input | 2 | Transfer-type code |
| xfer_start | input | 1 | Transfer-start strobe |
| xfer_burst | input | 1 | High for a four-beat burst |
| dram_size | input | 2 | DRAM module-size code |
| cs_n | output | 6 | Active-low chip-selects, one per device |
| xfer_ack | output | 1 | Transfer acknowledge, one pulse per beat |
| xfer_err | output | 1 | No-response flag, one-cycle pulse |

## Verification
The hardest case to reach from the ports is a second start that arrives while a burst is still being paced. A careless design would restart its counters or switch the chip-select. The stimulus forces this case with a directed DRAM burst. One cycle into that burst it raises the start again, this time with a flash address, and then checks the whole acknowledge pattern and chip-select history against a lone burst. Random cycles also draw addresses from every window, from the gaps, and with random upper nibbles and size codes. These random cycles reach the aliasing, the DRAM top limits and the CPU-space no-response path.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  typedef enum logic [2:0] {
    DEV_NONE  = 3'd0,
    DEV_FLASH = 3'd1,
    DEV_SRAMA = 3'd2,
    DEV_SRAMB = 3'd3,
    DEV_DRAM  = 3'd4,
    DEV_IMEM  = 3'd5,
    DEV_STAT  = 3'd6
  } dev_e;

  localparam int unsigned DEV_COUNT = 6;

  localparam logic [31:0] ONBOARD_MASK = 32'h0FFF_FFFF;
  localparam logic [31:0] FLASH_LIMIT  = 32'h0020_0000;
  localparam logic [31:0] SRAMA_BASE   = 32'h003C_0000;
  localparam logic [31:0] SRAMB_BASE   = 32'h003E_0000;
  localparam logic [31:0] SRAM_SPAN    = 32'h0001_0000;
  localparam logic [31:0] DRAM_BASE    = 32'h0040_0000;
  localparam logic [31:0] DRAM_UNIT    = 32'h0010_0000;
  localparam logic [31:0] IMEM_BASE    = 32'h0121_0000;
  localparam logic [31:0] STAT_BASE    = 32'h0123_0000;
  localparam logic [31:0] REG_SPAN     = 32'h0000_2000;

endpackage

// File: rtl/bsp_decode.sv
module bsp_decode
  import bsp_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CS_W   = DEV_COUNT
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        tmod,
  input  logic [1:0]        ttype,
  input  logic [1:0]        dsize,
  output dev_e              dev,
  output logic [CS_W-1:0]   sel
);

  logic [31:0] local_a;
  logic [31:0] dram_top;
  logic        cpu_space;

  assign local_a   = 32'(addr) & ONBOARD_MASK;
  assign dram_top  = DRAM_BASE + (DRAM_UNIT << dsize);
  assign cpu_space = (tmod == 3'b111) || (ttype == 2'b11);

  always_comb begin
    dev = DEV_NONE;
    if (!cpu_space) begin
      if (local_a < FLASH_LIMIT)
        dev = DEV_FLASH;
      else if (local_a >= SRAMA_BASE && local_a < SRAMA_BASE + SRAM_SPAN)
        dev = DEV_SRAMA;
      else if (local_a >= SRAMB_BASE && local_a < SRAMB_BASE + SRAM_SPAN)
        dev = DEV_SRAMB;
      else if (local_a >= DRAM_BASE && local_a < dram_top)
        dev = DEV_DRAM;
      else if (local_a >= IMEM_BASE && local_a < IMEM_BASE + REG_SPAN)
        dev = DEV_IMEM;
      else if (local_a >= STAT_BASE && local_a < STAT_BASE + REG_SPAN)
        dev = DEV_STAT;
    end
  end

  for (genvar g = 0; g < CS_W; g++) begin : g_sel
    assign sel[g] = (int'(dev) == g + 1);
  end

endmodule

// File: rtl/bsp_beat_seq.sv
module bsp_beat_seq
  import bsp_pkg::*;
#(
  parameter int unsigned CS_W        = DEV_COUNT,
  parameter int unsigned BURST_BEATS = 4,
  parameter int unsigned FLASH_LEAD  = 4,
  parameter int unsigned FLASH_NEXT  = 4,
  parameter int unsigned SRAM_LEAD   = 3,
  parameter int unsigned SRAM_NEXT   = 1,
  parameter int unsigned DRAM_LEAD   = 3,
  parameter int unsigned DRAM_NEXT   = 2,
  parameter int unsigned REG_LEAD    = 2,
  parameter int unsigned TIMEOUT     = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            burst,
  input  dev_e            dev,
  input  logic [CS_W-1:0] sel,
  output logic [CS_W-1:0] cs_n,
  output logic            ack,
  output logic            err,
  output logic            busy
);

  localparam int unsigned CNT_W = $clog2(TIMEOUT) + 1;
  localparam int unsigned BT_W  = $clog2(BURST_BEATS) + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD, S_WAIT} seq_e;

  seq_e             state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] next_m1;
  logic [BT_W-1:0]  beats_left;
  logic [CNT_W-1:0] lead_m1;
  logic [CNT_W-1:0] gap_m1;
  logic             single;

  always_comb begin
    single = !burst;
    case (dev)
      DEV_FLASH: begin
        lead_m1 = CNT_W'(FLASH_LEAD - 1);
        gap_m1  = CNT_W'(FLASH_NEXT - 1);
      end
      DEV_SRAMA, DEV_SRAMB: begin
        lead_m1 = CNT_W'(SRAM_LEAD - 1);
        gap_m1  = CNT_W'(SRAM_NEXT - 1);
      end
      DEV_DRAM: begin
        lead_m1 = CNT_W'(DRAM_LEAD - 1);
        gap_m1  = CNT_W'(DRAM_NEXT - 1);
      end
      default: begin
        lead_m1 = CNT_W'(REG_LEAD - 1);
        gap_m1  = CNT_W'(REG_LEAD - 1);
        single  = 1'b1;
      end
    endcase
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      next_m1    <= '0;
      beats_left <= '0;
      cs_n       <= '1;
      ack        <= 1'b0;
      err        <= 1'b0;
    end else begin
      err <= 1'b0;
      case (state)
        S_IDLE: begin
          ack <= 1'b0;
          if (start) begin
            if (dev == DEV_NONE) begin
              state <= S_WAIT;
              cnt   <= CNT_W'(TIMEOUT - 1);
            end else begin
              state      <= S_RUN;
              cs_n       <= ~sel;
              cnt        <= lead_m1;
              next_m1    <= gap_m1;
              beats_left <= single ? '0 : BT_W'(BURST_BEATS - 1);
            end
          end
        end
        S_RUN: begin
          if (cnt == '0) begin
            ack <= 1'b1;
            cnt <= next_m1;
            if (beats_left == '0) state <= S_HOLD;
            else beats_left <= beats_left - 1'b1;
          end else begin
            ack <= 1'b0;
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: begin
          ack   <= 1'b0;
          cs_n  <= '1;
          state <= S_IDLE;
        end
        default: begin
          if (cnt == '0) begin
            err   <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/bus_select_pacer.sv
module bus_select_pacer
  import bsp_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CS_W        = DEV_COUNT,
  parameter int unsigned BURST_BEATS = 4,
  parameter int unsigned FLASH_LEAD  = 4,
  parameter int unsigned FLASH_NEXT  = 4,
  parameter int unsigned SRAM_LEAD   = 3,
  parameter int unsigned SRAM_NEXT   = 1,
  parameter int unsigned DRAM_LEAD   = 3,
  parameter int unsigned DRAM_NEXT   = 2,
  parameter int unsigned REG_LEAD    = 2,
  parameter int unsigned TIMEOUT     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        xfer_mod,
  input  logic [1:0]        xfer_type,
  input  logic              xfer_start,
  input  logic              xfer_burst,
  input  logic [1:0]        dram_size,
  output logic [CS_W-1:0]   cs_n,
  output logic              xfer_ack,
  output logic              xfer_err
);

  dev_e            dec_dev;
  logic [CS_W-1:0] dec_sel;
  logic            seq_busy;

  bsp_decode #(
    .ADDR_W (ADDR_W),
    .CS_W   (CS_W)
  ) u_decode (
    .addr  (bus_addr),
    .tmod  (xfer_mod),
    .ttype (xfer_type),
    .dsize (dram_size),
    .dev   (dec_dev),
    .sel   (dec_sel)
  );

  bsp_beat_seq #(
    .CS_W        (CS_W),
    .BURST_BEATS (BURST_BEATS),
    .FLASH_LEAD  (FLASH_LEAD),
    .FLASH_NEXT  (FLASH_NEXT),
    .SRAM_LEAD   (SRAM_LEAD),
    .SRAM_NEXT   (SRAM_NEXT),
    .DRAM_LEAD   (DRAM_LEAD),
    .DRAM_NEXT   (DRAM_NEXT),
    .REG_LEAD    (REG_LEAD),
    .TIMEOUT     (TIMEOUT)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (xfer_start),
    .burst (xfer_burst),
    .dev   (dec_dev),
    .sel   (dec_sel),
    .cs_n  (cs_n),
    .ack   (xfer_ack),
    .err   (xfer_err),
    .busy  (seq_busy)
  );

endmodule

// File: rtl/bus_select_pacer_chk.sv
module bus_select_pacer_chk #(
  parameter int unsigned CS_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xfer_start,
  input logic [2:0]      xfer_mod,
  input logic [CS_W-1:0] cs_n,
  input logic            xfer_ack,
  input logic            xfer_err,
  input logic            seq_busy
);

  assert_single_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);

  assert_cpu_space_no_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !seq_busy && xfer_mod == 3'b111) |=> (cs_n == '1));

  assert_err_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> (cs_n == '1 && !xfer_ack));

  assert_err_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |=> !xfer_err);

  assert_ack_under_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> (cs_n != '1));

  assert_release_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == '1 && $past(cs_n) != '1) |-> $past(xfer_ack));

endmodule

bind bus_select_pacer bus_select_pacer_chk #(.CS_W(CS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_start (xfer_start),
  .xfer_mod   (xfer_mod),
  .cs_n       (cs_n),
  .xfer_ack   (xfer_ack),
  .xfer_err   (xfer_err),
  .seq_busy   (seq_busy)
);

// File: tb/bus_select_pacer_bench.sv
module bus_select_pacer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [2:0]  xfer_mod = '0;
  logic [1:0]  xfer_type = '0;
  logic        xfer_start = 1'b0;
  logic        xfer_burst = 1'b0;
  logic [1:0]  dram_size = '0;
  logic [5:0]  cs_n;
  logic        xfer_ack;
  logic        xfer_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_select_pacer u_bus_select_pacer (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .xfer_mod(xfer_mod),
    .xfer_type(xfer_type), .xfer_start(xfer_start), .xfer_burst(xfer_burst),
    .dram_size(dram_size), .cs_n(cs_n), .xfer_ack(xfer_ack), .xfer_err(xfer_err)
  );

  // expected device index: 0 none, 1 flash, 2/3 SRAM, 4 DRAM, 5 internal, 6 status
  function automatic int exp_dev(input logic [31:0] a, input logic [2:0] tm,
                                 input logic [1:0] tt, input logic [1:0] sz);
    logic [27:0] o;
    o = a[27:0];
    if (tm == 3'b111 || tt == 2'b11) return 0;
    if (o <= 28'h01F_FFFF) return 1;
    if (o >= 28'h03C_0000 && o <= 28'h03C_FFFF) return 2;
    if (o >= 28'h03E_0000 && o <= 28'h03E_FFFF) return 3;
    if (o >= 28'h040_0000 && o < 28'h040_0000 + (28'h010_0000 << sz)) return 4;
    if (o >= 28'h121_0000 && o <= 28'h121_1FFF) return 5;
    if (o >= 28'h123_0000 && o <= 28'h123_1FFF) return 6;
    return 0;
  endfunction

  function automatic string dev_tag(input int d);
    case (d)
      1: return "R6";
      2, 3: return "R7";
      4: return "R8";
      5, 6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one transfer; mid=1 raises a second start (flash address) one cycle in (R12)
  task automatic run_xfer(input logic [31:0] a, input logic [2:0] tm, input logic [1:0] tt,
                          input logic bst, input logic [1:0] sz, input bit mid, input string tag);
    int d, lead, gap, beats, pos, last;
    logic [31:0] ack_exp, ack_act, err_exp, err_act;
    logic [5:0] sel_exp, cs_seen;
    bit cs_ok;
    d = exp_dev(a, tm, tt, sz);
    ack_exp = '0; err_exp = '0; last = -1;
    sel_exp = (d == 0) ? 6'h00 : 6'(1 << (d - 1));
    case (d)
      1: begin lead = 4; gap = 4; beats = bst ? 4 : 1; end
      2, 3: begin lead = 3; gap = 1; beats = bst ? 4 : 1; end
      4: begin lead = 3; gap = 2; beats = bst ? 4 : 1; end
      5, 6: begin lead = 2; gap = 2; beats = 1; end
      default: begin lead = 0; gap = 0; beats = 0; end
    endcase
    pos = lead;
    for (int b = 0; b < beats; b++) begin
      ack_exp[pos] = 1'b1; last = pos; pos += gap;
    end
    if (d == 0) err_exp[16] = 1'b1;
    @(negedge clk);
    bus_addr = a; xfer_mod = tm; xfer_type = tt; xfer_burst = bst; dram_size = sz;
    xfer_start = 1'b1;
    ack_act = '0; err_act = '0; cs_ok = 1; cs_seen = '1;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      ack_act[k] = xfer_ack;
      err_act[k] = xfer_err;
      if (k <= last) begin
        if (cs_n != ~sel_exp) begin cs_ok = 0; cs_seen = cs_n; end
      end else if (cs_n != 6'h3F) begin
        cs_ok = 0; cs_seen = cs_n;
      end
      if (mid && k == 0) begin
        bus_addr = 32'h0000_1000; xfer_mod = 3'b001; xfer_type = 2'b00; xfer_burst = 1'b0;
        xfer_start = 1'b1;
      end else begin
        xfer_start = 1'b0;
      end
    end
    check(ack_act == ack_exp, tag, "ack cycles", ack_act, ack_exp);
    check(err_act == err_exp, tag, "err cycles", err_act, err_exp);
    // R2 selection bit, R11 release one cycle after the last ack
    check(cs_ok, (d == 0) ? tag : "R2/R11", "chip-select history",
          32'(cs_seen), 32'(~sel_exp));
  endtask

  function automatic logic [31:0] rand_addr();
    logic [31:0] base, off;
    case ($urandom % 8)
      0: begin base = 32'h0000_0000; off = $urandom % 32'h20_0000; end
      1: begin base = 32'h003C_0000; off = $urandom % 32'h1_0000; end
      2: begin base = 32'h003E_0000; off = $urandom % 32'h1_0000; end
      3: begin base = 32'h0040_0000; off = $urandom % 32'h90_0000; end
      4: begin base = 32'h0121_0000; off = $urandom % 32'h2000; end
      5: begin base = 32'h0123_0000; off = $urandom % 32'h2000; end
      6: begin base = 32'h0020_0000; off = $urandom % 32'h1C_0000; end
      default: begin base = 32'h0; off = $urandom; end
    endcase
    return {4'($urandom), 28'(base + off)};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(cs_n == 6'h3F && !xfer_ack && !xfer_err, "R1", "reset outputs",
          {24'h0, cs_n, xfer_ack, xfer_err}, {24'h0, 6'h3F, 2'b00});
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n == 6'h3F && !xfer_ack && !xfer_err, "R1", "after reset release",
          {24'h0, cs_n, xfer_ack, xfer_err}, {24'h0, 6'h3F, 2'b00});

    // directed corners
    run_xfer(32'h0000_0010, 3'b010, 2'b00, 1'b1, 2'd0, 0, "R6");
    run_xfer(32'h003C_0040, 3'b001, 2'b00, 1'b1, 2'd0, 0, "R7");
    run_xfer(32'h003E_FFF0, 3'b101, 2'b00, 1'b0, 2'd0, 0, "R7");
    run_xfer(32'h0040_0000, 3'b001, 2'b00, 1'b1, 2'd0, 0, "R8");
    run_xfer(32'h0121_0100, 3'b101, 2'b00, 1'b1, 2'd0, 0, "R9");
    run_xfer(32'h0123_0004, 3'b101, 2'b00, 1'b0, 2'd0, 0, "R3");
    run_xfer(32'hF000_0000, 3'b001, 2'b00, 1'b0, 2'd0, 0, "R3");
    run_xfer(32'h0123_1FFE, 3'b001, 2'b00, 1'b1, 2'd0, 0, "R3");
    for (int s = 0; s < 4; s++) begin
      logic [31:0] top;
      top = 32'h0040_0000 + (32'h0010_0000 << s);
      run_xfer(top - 32'd4, 3'b001, 2'b00, 1'b0, 2'(s), 0, "R4");
      run_xfer(top, 3'b001, 2'b00, 1'b0, 2'(s), 0, "R4");
    end
    run_xfer(32'h0000_0100, 3'b111, 2'b11, 1'b0, 2'd0, 0, "R5");
    run_xfer(32'h003C_0000, 3'b111, 2'b00, 1'b0, 2'd0, 0, "R5");
    run_xfer(32'h0030_0000, 3'b001, 2'b00, 1'b0, 2'd0, 0, "R10");
    run_xfer(32'h0040_0100, 3'b001, 2'b00, 1'b1, 2'd3, 1, "R12");
    run_xfer(32'h0130_0000, 3'b001, 2'b00, 1'b0, 2'd0, 1, "R12");

    // constrained random cycles
    for (int i = 0; i < 120; i++) begin
      logic [31:0] a;
      logic [2:0] tm;
      logic [1:0] tt, sz;
      logic bst;
      a   = rand_addr();
      tm  = (($urandom % 8) == 0) ? 3'b111 : 3'($urandom % 7);
      tt  = (($urandom % 8) == 0) ? 2'b11 : 2'b00;
      sz  = 2'($urandom);
      bst = 1'($urandom);
      run_xfer(a, tm, tt, bst, sz, 0, dev_tag(exp_dev(a, tm, tt, sz)));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule